// File: doc/BRIEF.md
# Frame-Synchronised Configuration Register Bank

This block holds the configuration words of a display compositor behind a simple memory-mapped bus. Every software write lands in a shadow copy. A second, active copy feeds the pixel pipeline, and it changes only on a vertical-blank pulse. Tearing is avoided because a half-written set of registers never reaches the pipeline mid-frame.

A buffer-control word picks between two commit policies. With automatic loading on, every vertical blank copies the whole shadow set into the active set. With automatic loading off, software arms a load request. The copy then happens at the next vertical blank, and the request bit clears itself. Software polls that bit before it starts preparing the next update. The bank also holds a mode word with module enable, start, per-layer enable and interlace bits, and a window of per-layer attribute words that reset to zero.

Top module: `frame_sync_regbank`

## Requirements
- R1: After reset, every shadow word, every active word and both buffer-control bits are zero, and all outputs are zero.
- R2: A write to the mode word (offset 0x000) or to attribute word i (offset ATTR_BASE + 4*i, default base 0x800, 16 words) changes the shadow copy, which reads back on the next cycle. The active outputs keep their old value.
- R3: The mode word stores bit 0 (enable), bit 1 (start), bits 4 to 4+LAYERS-1 (layer enables) and bit 4+LAYERS (interlace, bit 8 by default). All other bits read back as zero.
- R4: The buffer-control word at offset 0x004 reads live. Bit 0 is the load request and bit 1 is the autoload-disable flag. Writing 1 to bit 0 arms a request. Writing 0 to bit 0 leaves a pending request armed.
- R5: With autoload disabled, the active copy changes only on a vertical-blank cycle while a request is pending. It then takes the shadow values held before that clock edge.
- R6: A pending request reads back as 1 until the transfer edge and as 0 after it.
- R7: With autoload enabled, every vertical-blank cycle copies shadow to active, whether or not a request is pending.
- R8: A write in the same cycle as a transfer lands in the shadow copy only. It reaches the active copy at the next transfer.
- R9: A request written in the same cycle as a transfer remains armed after that transfer.
- R10: Writes to unmapped offsets, or to offsets above MAX_OFF (default 0x5800), change no state. Reads of those offsets return zero. The two low address bits are ignored.
- R11: The outputs eng_enable, eng_start, layer_en and interlace_en reflect the active mode word bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when set together with bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| vblank | input | 1 | One-cycle frame-boundary pulse |
| eng_enable | output | 1 | Active module enable |
| eng_start | output | 1 | Active start control |
| layer_en | output | LAYERS | Active per-layer enables |
| interlace_en | output | 1 | Active interlace mode |
| attr_active | output | 32*ATTR_WORDS | Active attribute words, word i at bits 32*i upward |

## Verification
The bench goes after three collisions:
- A write that coincides with a transfer. A design that let it through would show the new value on the active outputs one frame early.
- A load request written in the transfer cycle. A design where clear beats set would drop that commit, and software polling would see 0 too soon.
- A write of zero to the request bit. A design that treated that write as a clear would lose a pending commit.

The bench also sweeps every attribute word with distinct patterns, checks the mode-word mask, and writes to holes and to addresses above the top offset. A bad decode there would alias into real registers.

// File: rtl/frame_sync_regbank.sv
module frame_sync_regbank #(
  parameter int LAYERS     = 4,
  parameter int ATTR_WORDS = 16,
  parameter int ADDR_W     = 15,
  parameter int ATTR_BASE  = 'h800,
  parameter int MAX_OFF    = 'h5800
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic                       vblank,
  output logic                       eng_enable,
  output logic                       eng_start,
  output logic [LAYERS-1:0]          layer_en,
  output logic                       interlace_en,
  output logic [32*ATTR_WORDS-1:0]   attr_active
);
  localparam int WI_W = ADDR_W - 2;
  localparam int AIW  = (ATTR_WORDS > 1) ? $clog2(ATTR_WORDS) : 1;
  localparam logic [WI_W-1:0]   A_LO  = WI_W'(ATTR_BASE / 4);
  localparam logic [WI_W-1:0]   A_HI  = WI_W'(ATTR_BASE / 4 + ATTR_WORDS);
  localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_OFF);
  localparam logic [31:0] MODE_MASK = 32'((64'd1 << (LAYERS + 5)) - 1) & ~32'hC;

  logic [31:0] mode_sh, mode_act;
  logic [31:0] attr_sh  [ATTR_WORDS];
  logic [31:0] attr_act [ATTR_WORDS];
  logic        load_req, auto_dis;

  wire [WI_W-1:0] widx     = bus_addr[ADDR_W-1:2];
  wire            in_range = bus_addr <= MAX_A;
  wire            hit_mode = in_range && (widx == '0);
  wire            hit_buf  = in_range && (widx == WI_W'(1));
  wire            hit_attr = in_range && (widx >= A_LO) && (widx < A_HI);
  wire [WI_W-1:0] aoff     = widx - A_LO;
  wire [AIW-1:0]  aidx     = aoff[AIW-1:0];
  wire            wr       = bus_sel && bus_we;
  wire            arm      = wr && hit_buf && bus_wdata[0];
  wire            xfer     = vblank && (load_req || !auto_dis);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_sh  <= '0;
      mode_act <= '0;
      load_req <= 1'b0;
      auto_dis <= 1'b0;
      for (int i = 0; i < ATTR_WORDS; i++) begin
        attr_sh[i]  <= '0;
        attr_act[i] <= '0;
      end
    end else begin
      if (wr && hit_mode) mode_sh <= bus_wdata & MODE_MASK;
      if (wr && hit_attr) attr_sh[aidx] <= bus_wdata;
      if (wr && hit_buf)  auto_dis <= bus_wdata[1];
      if (arm)            load_req <= 1'b1;
      else if (xfer)      load_req <= 1'b0;
      if (xfer) begin
        mode_act <= mode_sh;
        for (int i = 0; i < ATTR_WORDS; i++) attr_act[i] <= attr_sh[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_mode)      bus_rdata = mode_sh;
    else if (hit_buf)  bus_rdata = {30'd0, auto_dis, load_req};
    else if (hit_attr) bus_rdata = attr_sh[aidx];
  end

  assign eng_enable   = mode_act[0];
  assign eng_start    = mode_act[1];
  assign layer_en     = mode_act[4 +: LAYERS];
  assign interlace_en = mode_act[4 + LAYERS];

  for (genvar g = 0; g < ATTR_WORDS; g++) begin : g_out
    assign attr_active[32*g +: 32] = attr_act[g];
  end

  p_hold_no_vblank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(mode_act) && $stable(attr_act[0]));
  p_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && auto_dis && !load_req |=> $stable(mode_act));
  p_auto_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && !auto_dis |=> mode_act == $past(mode_sh));
  p_req_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && load_req && !arm |=> !load_req);
  p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && !vblank |=> load_req);
  p_req_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> load_req);
  p_mode_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sh & ~MODE_MASK) == 32'd0);
endmodule

// File: tb/frame_sync_regbank_tb.sv
module frame_sync_regbank_tb;
  localparam int PERIOD = 10;
  localparam int LAYERS = 4;
  localparam int AW     = 16;
  localparam int ADDR_W = 15;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0, vblank = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic eng_enable, eng_start, interlace_en;
  logic [LAYERS-1:0] layer_en;
  logic [32*AW-1:0] attr_active;
  int checks = 0, errors = 0;
  logic [31:0] pat [AW];

  always #(PERIOD/2) clk = ~clk;

  frame_sync_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vblank(vblank), .eng_enable(eng_enable), .eng_start(eng_start),
    .layer_en(layer_en), .interlace_en(interlace_en), .attr_active(attr_active));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic cyc(input bit w, input int a, input logic [31:0] d, input bit vb);
    @(negedge clk);
    bus_sel = w; bus_we = w; bus_addr = ADDR_W'(a); bus_wdata = d; vblank = vb;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; vblank = 0;
  endtask

  function automatic logic [31:0] act_word(int i);
    return attr_active[32*i +: 32];
  endfunction

  function automatic logic [31:0] mode_out();
    return {23'd0, interlace_en, layer_en, 2'b00, eng_start, eng_enable};
  endfunction

  initial begin
    #(PERIOD*100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < AW; i++) pat[i] = 32'hA5000000 ^ (32'(i) * 32'h01010101) + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode out", mode_out(), 0);
    chk_rd("R1 mode rd", 'h000, 0);
    chk_rd("R1 buf rd", 'h004, 0);
    for (int i = 0; i < AW; i++) begin
      chk_rd("R1 attr rd", 'h800 + 4*i, 0);
      chk("R1 attr out", act_word(i), 0);
    end

    cyc(1, 'h004, 32'h2, 0);
    chk_rd("R4 autoload disable", 'h004, 32'h2);

    // R2 sweep of the attribute window
    for (int i = 0; i < AW; i++) cyc(1, 'h800 + 4*i, pat[i], 0);
    for (int i = 0; i < AW; i++) begin
      chk_rd("R2 attr shadow", 'h800 + 4*i, pat[i]);
      chk("R2 attr active held", act_word(i), 0);
    end
    cyc(1, 'h000, 32'hFFFFFFFF, 0);
    chk_rd("R3 mode mask", 'h000, 32'h1F3);
    chk("R2 mode active held", mode_out(), 0);

    // R5 vblank with no request does nothing
    cyc(0, 0, 0, 1);
    chk("R5 no commit", mode_out(), 0);
    chk("R5 no commit attr", act_word(3), 0);

    cyc(1, 'h004, 32'h3, 0);
    chk_rd("R6 pending reads 1", 'h004, 32'h3);
    cyc(1, 'h004, 32'h2, 0);
    chk_rd("R4 zero does not clear", 'h004, 32'h3);
    chk("R5 still held before vblank", act_word(0), 0);
    cyc(0, 0, 0, 1);
    chk_rd("R6 cleared after transfer", 'h004, 32'h2);
    chk("R11 mode outputs", mode_out(), 32'h1F3);
    for (int i = 0; i < AW; i++) chk("R5 committed attr", act_word(i), pat[i]);

    cyc(1, 'h000, 32'h100, 0);
    cyc(1, 'h004, 32'h3, 0);
    cyc(0, 0, 0, 1);
    chk("R11 interlace only", mode_out(), 32'h100);

    // R7 autoload on
    cyc(1, 'h004, 32'h0, 0);
    cyc(1, 'h804, 32'h12345678, 0);
    chk("R7 before vblank", act_word(1), pat[1]);
    cyc(0, 0, 0, 1);
    chk("R7 auto copy", act_word(1), 32'h12345678);
    chk_rd("R7 no request", 'h004, 32'h0);

    // R8 write colliding with transfer
    cyc(1, 'h004, 32'h3, 0);
    cyc(1, 'h800, 32'hDEADBEEF, 1);
    chk("R8 collide not active", act_word(0), pat[0]);
    chk_rd("R8 collide in shadow", 'h800, 32'hDEADBEEF);
    chk_rd("R6 cleared on collide", 'h004, 32'h2);
    cyc(1, 'h004, 32'h3, 0);
    cyc(0, 0, 0, 1);
    chk("R8 later commit", act_word(0), 32'hDEADBEEF);

    // R9 request armed in the transfer cycle
    cyc(1, 'h004, 32'h3, 0);
    cyc(1, 'h004, 32'h3, 1);
    chk_rd("R9 set wins", 'h004, 32'h3);
    cyc(0, 0, 0, 1);
    chk_rd("R9 then clears", 'h004, 32'h2);

    // R10 holes and out of range
    cyc(1, 'h008, 32'hFFFFFFFF, 0);
    cyc(1, 'h840, 32'hFFFFFFFF, 0);
    cyc(1, 'h5804, 32'hFFFFFFFF, 0);
    cyc(1, 'h7FFC, 32'hFFFFFFFF, 0);
    cyc(1, 'h803, 32'h0BADF00D, 0);
    chk_rd("R10 low bits ignored", 'h800, 32'h0BADF00D);
    chk_rd("R10 hole reads 0", 'h008, 0);
    chk_rd("R10 past window reads 0", 'h840, 0);
    chk_rd("R10 above max reads 0", 'h5804, 0);
    chk_rd("R10 top reads 0", 'h7FFC, 0);
    chk_rd("R10 mode untouched", 'h000, 32'h100);
    chk_rd("R10 buf untouched", 'h004, 32'h2);
    for (int i = 1; i < AW; i++)
      chk_rd("R10 attr untouched", 'h800 + 4*i, (i == 1) ? 32'h12345678 : pat[i]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule